// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two eight-bit buses, A and B, in either direction or in both at once. Each direction has its own storage register. The A-to-B register takes a snapshot of bus A when its capture strobe rises, and the B-to-A register does the same for bus B. Each driven bus gets its data from one of two sources, chosen by that direction's select input: the live value of the opposite bus, or the stored snapshot.

Each bus pin is split into three signals: a resolved input, a driven value and a per-bit output enable. An enable bit of zero means the pin is released (high impedance), so the block stays synthesizable. A separate enable decides whether each bus is driven. Capture does not depend on the selects or the enables. When both directions are in live mode and both buses are enabled, each bus drives the other. The two buses then form a loop that keeps the last value once every outside driver has let go.

The capture strobes are sampled on the system clock. A capture happens at the clock edge where a strobe is high and was low at the previous edge.

Top module: `xcvr_top`

## Requirements
- R1: The data path is W bits wide (8 by default). Every driven bit is an uninverted copy of the same bit of its selected source.
- R2: At a clock edge where cap_ab is high and was low at the previous edge, the A-to-B register loads a_in. At every other edge it keeps its value, including while cap_ab stays high.
- R3: At a clock edge where cap_ba is high and was low at the previous edge, the B-to-A register loads b_in. At every other edge it keeps its value.
- R4: Capture ignores sel_ab, sel_ba, en_b and en_a_n. Both registers load in the same edge when both strobes rise together.
- R5: b_out equals a_in in the same cycle when sel_ab is 0 (live). b_out equals the A-to-B register when sel_ab is 1 (stored).
- R6: a_out equals b_in in the same cycle when sel_ba is 0 (live). a_out equals the B-to-A register when sel_ba is 1 (stored).
- R7: b_oe is all ones when en_b is 1 and all zeros when en_b is 0. a_oe is all ones when en_a_n is 0 and all zeros when en_a_n is 1. All zeros means the bus is released.
- R8: Set both selects to 0, en_b to 1 and en_a_n to 0. After the outside drivers release both buses, both buses keep the last value that was driven onto either of them.
- R9: While rst is high at a clock edge, both registers clear to zero. The reset is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of both registers |
| a_in | input | W | Resolved value on bus A |
| a_out | output | W | Value driven toward bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Resolved value on bus B |
| b_out | output | W | Value driven toward bus B |
| b_oe | output | W | Per-bit drive enable for bus B |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | Source for bus B: 0 live from A, 1 stored |
| sel_ba | input | 1 | Source for bus A: 0 live from B, 1 stored |
| en_b | input | 1 | Drive bus B, active high |
| en_a_n | input | 1 | Drive bus A, active low |

## Verification
Live transfers and enables are combinational, so they are due in the same cycle as their stimulus. A capture is due one edge after the strobe rises, and the stored value shows on the outputs right after that edge.

The bench changes its inputs five nanoseconds after a rising edge. It models the buses with a one-nanosecond resolution step, so the buses settle well before the falling edge, and it compares every output against its reference model at that falling edge. A strobe raised mid-cycle is therefore captured at the next rising edge and checked at the falling edge that follows. The hold loop is checked several cycles after the last outside driver lets go.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_capture.sv
`timescale 1ns/1ps
// Snapshot register: loads din at the edge where the strobe goes high.
module xcvr_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic fire;

  // The strobe history is not reset, so a strobe held high through reset
  // does not look like a new edge afterwards.
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign fire = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (fire) begin
      q <= din;
    end
  end
endmodule

// File: rtl/xcvr_drive.sv
`timescale 1ns/1ps
// Source choice and drive enable for one direction.
module xcvr_drive #(
  parameter int W          = 8,
  parameter bit ENABLE_LOW = 1'b0
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);
  import xcvr_pkg::*;

  src_sel_e src;
  logic     active;

  assign src = src_sel_e'(sel);

  always_comb begin
    case (src)
      SRC_STORED: dout = stored;
      default:    dout = live;
    endcase
  end

  generate
    if (ENABLE_LOW) begin : g_low
      assign active = ~en;
    end else begin : g_high
      assign active = en;
    end
  endgenerate

  assign oe = {W{active}};
endmodule

// File: rtl/xcvr_top.sv
`timescale 1ns/1ps
module xcvr_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_b,
  input  logic         en_a_n
);
  logic [W-1:0] st_ab;
  logic [W-1:0] st_ba;

  xcvr_capture #(.W(W)) cap_ab_i (
    .clk(clk), .rst(rst), .strobe(cap_ab), .din(a_in), .q(st_ab)
  );

  xcvr_capture #(.W(W)) cap_ba_i (
    .clk(clk), .rst(rst), .strobe(cap_ba), .din(b_in), .q(st_ba)
  );

  xcvr_drive #(.W(W), .ENABLE_LOW(1'b0)) drv_b_i (
    .sel(sel_ab), .live(a_in), .stored(st_ab), .en(en_b),
    .dout(b_out), .oe(b_oe)
  );

  xcvr_drive #(.W(W), .ENABLE_LOW(1'b1)) drv_a_i (
    .sel(sel_ba), .live(b_in), .stored(st_ba), .en(en_a_n),
    .dout(a_out), .oe(a_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_b,
  input logic         en_a_n,
  input logic [W-1:0] st_ab,
  input logic [W-1:0] st_ba
);
  p_cap_ab_r2: assert property (@(posedge clk) disable iff (rst)
    (cap_ab && !$past(cap_ab)) |=> (st_ab == $past(a_in)));

  p_keep_ab_r2: assert property (@(posedge clk) disable iff (rst)
    !(cap_ab && !$past(cap_ab)) |=> $stable(st_ab));

  p_cap_ba_r3: assert property (@(posedge clk) disable iff (rst)
    (cap_ba && !$past(cap_ba)) |=> (st_ba == $past(b_in)));

  p_keep_ba_r3: assert property (@(posedge clk) disable iff (rst)
    !(cap_ba && !$past(cap_ba)) |=> $stable(st_ba));

  p_live_b_r5: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |-> (b_out == a_in));

  p_live_a_r6: assert property (@(posedge clk) disable iff (rst)
    !sel_ba |-> (a_out == b_in));

  p_b_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (b_oe == (en_b ? {W{1'b1}} : {W{1'b0}})));

  p_a_oe_r7: assert property (@(posedge clk) disable iff (rst)
    (a_oe == (en_a_n ? {W{1'b0}} : {W{1'b1}})));
endmodule

bind xcvr_top xcvr_checker #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab),
  .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .en_b(en_b),
  .en_a_n(en_a_n), .st_ab(st_ab), .st_ba(st_ba)
);

// File: tb/xcvr_top_tb_top.sv
`timescale 1ns/1ps
module xcvr_top_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_bus = '0;
  logic [W-1:0] b_bus = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, en_b = 0, en_a_n = 1;
  logic ext_a_en = 0, ext_b_en = 0;
  logic [W-1:0] ext_a = '0, ext_b = '0;

  logic [W-1:0] ref_ab = '0, ref_ba = '0;
  logic mprev_ab = 0, mprev_ba = 0;
  logic cmp_on = 0;
  logic done = 0;
  int total = 0;
  int fails = 0;

  xcvr_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_bus), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab),
    .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba), .en_b(en_b),
    .en_a_n(en_a_n)
  );

  // 50 MHz clock, edges offset by half a nanosecond from the bus steps.
  initial begin
    #0.5;
    forever #10 clk = ~clk;
  end

  // Bus resolution in 1 ns steps: an outside driver wins, then the block,
  // and an undriven bit keeps its last value.
  always begin
    #1;
    a_bus = ext_a_en ? ext_a : ((a_oe & a_out) | (~a_oe & a_bus));
    b_bus = ext_b_en ? ext_b : ((b_oe & b_out) | (~b_oe & b_bus));
  end

  // Reference model of the two snapshot registers.
  always @(posedge clk) begin
    if (rst) begin
      ref_ab <= '0;
      ref_ba <= '0;
    end else begin
      if (cap_ab && !mprev_ab) ref_ab <= a_bus;
      if (cap_ba && !mprev_ba) ref_ba <= b_bus;
    end
    mprev_ab <= cap_ab;
    mprev_ba <= cap_ba;
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Comparison on every falling edge.
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(sel_ab ? "R5 R1 b_out stored" : "R5 R1 b_out live", b_out, sel_ab ? ref_ab : a_bus);
      chk(sel_ba ? "R6 R1 a_out stored" : "R6 R1 a_out live", a_out, sel_ba ? ref_ba : b_bus);
      chk("R7 b_oe", b_oe, en_b ? {W{1'b1}} : {W{1'b0}});
      chk("R7 a_oe", a_oe, en_a_n ? {W{1'b0}} : {W{1'b1}});
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    cmp_on = 1;

    // R9: stored values read as zero after reset
    sel_ab = 1; sel_ba = 1; en_b = 1; en_a_n = 0;
    tick();
    @(negedge clk);
    chk("R9 b_out after reset", b_out, 8'h00);
    chk("R9 a_out after reset", a_out, 8'h00);

    // R4: both strobes rise together with the buses driven from outside
    tick();
    en_b = 0; en_a_n = 1;
    ext_a_en = 1; ext_a = 8'h3C; ext_b_en = 1; ext_b = 8'hC3;
    tick();
    cap_ab = 1; cap_ba = 1;
    tick();
    cap_ab = 0; cap_ba = 0;
    ext_a_en = 0; ext_b_en = 0;
    en_b = 1; en_a_n = 0;
    tick();
    @(negedge clk);
    chk("R2 R4 joint capture b_out", b_out, 8'h3C);
    chk("R3 R4 joint capture a_out", a_out, 8'hC3);

    // R4: capture while the block drives both buses from storage
    tick();
    cap_ab = 1;
    tick();
    cap_ab = 0;
    tick();
    @(negedge clk);
    chk("R4 capture under enable", b_out, 8'hC3);
    chk("R3 register kept", a_out, 8'hC3);

    // R2: a strobe held high captures only once
    tick();
    en_b = 0; en_a_n = 1;
    ext_a_en = 1; ext_a = 8'h11;
    tick();
    cap_ab = 1;
    tick();
    ext_a = 8'h22;
    tick();
    tick();
    cap_ab = 0;
    tick();
    @(negedge clk);
    chk("R2 held strobe", b_out, 8'h11);

    // R1 R5 R6 R7: sweep of selects, enables, outside drivers and strobes
    for (int i = 0; i < 64; i++) begin
      tick();
      sel_ab = i[0]; sel_ba = i[1]; en_b = i[2]; en_a_n = i[3];
      ext_a_en = i[3] & i[4];
      ext_a = 8'(i * 37 + 5);
      ext_b_en = ~i[2] & i[5];
      ext_b = ~8'(i * 53);
      cap_ab = (i % 3 == 0);
      cap_ba = (i % 5 == 0);
    end
    tick();
    cap_ab = 0; cap_ba = 0;

    // R8: loop holds the value after the outside driver on A lets go
    sel_ab = 0; sel_ba = 0; en_b = 1; en_a_n = 0;
    ext_b_en = 0; ext_a_en = 1; ext_a = 8'h5A;
    tick();
    tick();
    ext_a_en = 0;
    repeat (3) tick();
    @(negedge clk);
    chk("R8 hold on A", a_bus, 8'h5A);
    chk("R8 hold on B", b_bus, 8'h5A);

    // R8: new value brought in from B, then released
    tick();
    ext_b_en = 1; ext_b = 8'hA5;
    tick();
    tick();
    ext_b_en = 0;
    repeat (3) tick();
    @(negedge clk);
    chk("R8 hold on A after B", a_bus, 8'hA5);
    chk("R8 hold on B after B", b_bus, 8'hA5);

    // R9: reset in mid run clears stored data
    tick();
    sel_ab = 1; sel_ba = 1;
    en_b = 0; en_a_n = 1;
    ext_a_en = 1; ext_a = 8'h77; ext_b_en = 1; ext_b = 8'h99;
    tick();
    cap_ab = 1; cap_ba = 1;
    tick();
    cap_ab = 0; cap_ba = 0;
    tick();
    @(negedge clk);
    chk("R2 before reset", b_out, 8'h77);
    chk("R3 before reset", a_out, 8'h99);
    tick();
    rst = 1;
    tick();
    rst = 0;
    tick();
    @(negedge clk);
    chk("R9 b_out after mid reset", b_out, 8'h00);
    chk("R9 a_out after mid reset", a_out, 8'h00);

    tick();
    done = 1;
    finish_run();
  end
endmodule